// File: doc/BRIEF.md
# Carry and Tagged Integer Arithmetic Unit

This unit performs the arithmetic half of a 64-bit integer datapath. It supports the following operations:

- plain add and subtract;
- add and subtract that chain through a caller-supplied carry bit;
- an unsigned and a signed 32x32 multiply;
- an add on tagged words that raises a trap when either word carries a tag or the 32-bit sum overflows.

The result and its write enable are combinational from the operands. The high product word (Y) and the four condition flags are held in registers and change on the clock edge that follows an accepted operation. A tag-overflow trap is reported as a one-cycle pulse in that same cycle.

A caller presents an operation with `in_valid` high for one cycle. It takes the result and write enable in that cycle and reads the updated flags, Y and trap pulse one cycle later. The carry bit used by the chained operations comes in on `carry_in`. This lets the caller feed back `flag_c32` or any other carry source.

Top module: `arith_tag_unit`

## Requirements
- R1: Code 0 (add) gives `src_a + src_b`, and code 1 (subtract) gives `src_a - src_b`, both modulo 2^64. `result_we` is high whenever `in_valid` is high with a code from 0 to 5, and also for code 6 when it does not trap.
- R2: Code 2 (add with carry) gives `src_a + src_b + carry_in`. Code 3 (subtract with borrow) gives `src_a + ~src_b + 1 - carry_in`, which equals `src_a - src_b - carry_in`.
- R3: For codes 0, 2 and 6, `flag_c32` and `flag_c64` take the carry out of bits 31 and 63 of the sum. For codes 1 and 3 they take the inverted carry out of those bits, which is the borrow. The flags change on the clock edge after the operation.
- R4: `flag_v32` and `flag_v64` are set on signed overflow of the 32-bit and 64-bit views. For adds, overflow means the operands share a sign and the result's sign differs from it. For subtracts, it means the operand signs differ and the result's sign differs from the minuend's sign.
- R5: Code 4 (unsigned multiply) gives the product of the low 32 bits of both operands, taken as unsigned, and loads `y_reg` with product bits 63:32 on the next edge.
- R6: Code 5 (signed multiply) gives the 64-bit product of the low 32 bits of both operands, taken as two's-complement, and loads `y_reg` with product bits 63:32 on the next edge.
- R7: Code 6 (tagged add) traps when `src_a[1:0]` is nonzero, when `src_b[1:0]` is nonzero, or when bit 31 of both operands is equal and bit 31 of the sum differs. A trap does three things:
  - `result_we` is low in that cycle;
  - `tag_trap` is high for exactly the following cycle;
  - the four flags are left unchanged.
- R8: A code-6 operation that does not trap writes `src_a + src_b` and updates the flags as an add with no carry in. `flag_v32` is therefore 0.
- R9: While `in_valid` is low, or when code 7 is presented, `result_we` is low. `y_reg`, the flags and `tag_trap` then stay at their previous value or return to 0.
- R10: After reset `y_reg` is 0, all four flags are 0 and `tag_trap` is 0.
- R11: Multiplies (codes 4 and 5) leave the four flags unchanged. Add, subtract and tagged-add operations (codes 0 to 3 and 6) leave `y_reg` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code, 0 to 7 as listed in the requirements |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| carry_in | input | 1 | Carry bit consumed by codes 2 and 3 |
| result | output | 64 | Combinational result |
| result_we | output | 1 | Destination write enable for this cycle |
| y_reg | output | 32 | Registered high product word |
| flag_c32 | output | 1 | Registered 32-bit carry/borrow flag |
| flag_v32 | output | 1 | Registered 32-bit signed overflow flag |
| flag_c64 | output | 1 | Registered 64-bit carry/borrow flag |
| flag_v64 | output | 1 | Registered 64-bit signed overflow flag |
| tag_trap | output | 1 | One-cycle tag-overflow trap pulse |

## Verification
The properties assume that `op_sel` and the operand tag bits are known whenever `in_valid` is high. They also assume a new operation may arrive on every cycle, so the flag and Y hold checks compare the values across exactly one edge. The bench drives every input at the falling edge and holds it for one full cycle. It keeps operands fully defined. Outside a directed step it drops `in_valid`, so a stray operation never overlaps a sampled result.

// File: rtl/arith_tag_pkg.sv
package arith_tag_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_ADDC = 3'd2,
      OP_SUBC = 3'd3,
      OP_UMUL = 3'd4,
      OP_SMUL = 3'd5,
      OP_TADD = 3'd6,
      OP_RSVD = 3'd7
   } op_e;

   typedef struct packed {
      logic c32;
      logic v32;
      logic c64;
      logic v64;
   } flag_t;

endpackage

// File: rtl/ata_adder.sv
module ata_adder #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         c_half,
   output logic         c_full,
   output logic         v_half,
   output logic         v_full
);
   localparam int H = W / 2;

   logic [H:0] lo_seg;
   logic [H:0] hi_seg;

   assign lo_seg = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
   assign hi_seg = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{H{1'b0}}, lo_seg[H]};

   assign sum    = {hi_seg[H-1:0], lo_seg[H-1:0]};
   assign c_half = lo_seg[H];
   assign c_full = hi_seg[H];
   assign v_half = (a[H-1] == b[H-1]) && (lo_seg[H-1] != a[H-1]);
   assign v_full = (a[W-1] == b[W-1]) && (hi_seg[H-1] != a[W-1]);
endmodule

// File: rtl/ata_mul.sv
module ata_mul #(
   parameter int W      = 64,
   parameter bit SHARED = 1'b1
) (
   input  logic [W/2-1:0] a_lo,
   input  logic [W/2-1:0] b_lo,
   input  logic           is_signed,
   output logic [W-1:0]   prod
);
   localparam int H = W / 2;

   generate
      if (SHARED) begin : g_shared
         logic [W-1:0] ext_a;
         logic [W-1:0] ext_b;
         assign ext_a = {{H{is_signed & a_lo[H-1]}}, a_lo};
         assign ext_b = {{H{is_signed & b_lo[H-1]}}, b_lo};
         assign prod  = ext_a * ext_b;
      end else begin : g_split
         logic        [W-1:0] u_prod;
         logic signed [W-1:0] s_prod;
         assign u_prod = {{H{1'b0}}, a_lo} * {{H{1'b0}}, b_lo};
         assign s_prod = $signed({{H{a_lo[H-1]}}, a_lo}) * $signed({{H{b_lo[H-1]}}, b_lo});
         assign prod   = is_signed ? s_prod : u_prod;
      end
   endgenerate
endmodule

// File: rtl/ata_state.sv
module ata_state
   import arith_tag_pkg::*;
#(
   parameter int H = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flag_we,
   input  flag_t        flag_d,
   input  logic         y_we,
   input  logic [H-1:0] y_d,
   input  logic         trap_d,
   output flag_t        flag_q,
   output logic [H-1:0] y_q,
   output logic         trap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         y_q    <= '0;
         trap_q <= 1'b0;
      end else begin
         if (flag_we) flag_q <= flag_d;
         if (y_we)    y_q    <= y_d;
         trap_q <= trap_d;
      end
   end
endmodule

// File: rtl/arith_tag_unit.sv
module arith_tag_unit
   import arith_tag_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int TAG_W      = 2,
   parameter bit SHARED_MUL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [2:0]          op_sel,
   input  logic [DATA_W-1:0]   src_a,
   input  logic [DATA_W-1:0]   src_b,
   input  logic                carry_in,
   output logic [DATA_W-1:0]   result,
   output logic                result_we,
   output logic [DATA_W/2-1:0] y_reg,
   output logic                flag_c32,
   output logic                flag_v32,
   output logic                flag_c64,
   output logic                flag_v64,
   output logic                tag_trap
);
   localparam int HALF_W = DATA_W / 2;

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 8) begin : g_bad_width
         $error("arith_tag_unit: DATA_W must be even and at least 8");
      end
      if (TAG_W < 1 || TAG_W >= HALF_W) begin : g_bad_tag
         $error("arith_tag_unit: TAG_W must lie between 1 and DATA_W/2-1");
      end
   endgenerate

   op_e                op;
   logic               is_sub, is_arith, is_mul, tag_bad, trap_now;
   logic               add_cin;
   logic [DATA_W-1:0]  b_eff, sum, prod;
   logic               c_half, c_full, v_half, v_full;
   flag_t              flag_d, flag_q;

   assign op = op_e'(op_sel);

   always_comb begin
      is_sub   = (op == OP_SUB) || (op == OP_SUBC);
      is_mul   = (op == OP_UMUL) || (op == OP_SMUL);
      is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDC) ||
                 (op == OP_SUBC) || (op == OP_TADD);
      unique case (op)
         OP_SUB:  add_cin = 1'b1;
         OP_ADDC: add_cin = carry_in;
         OP_SUBC: add_cin = ~carry_in;
         default: add_cin = 1'b0;
      endcase
   end

   assign b_eff = is_sub ? ~src_b : src_b;

   ata_adder #(.W(DATA_W)) u_add (
      .a(src_a), .b(b_eff), .cin(add_cin), .sum(sum),
      .c_half(c_half), .c_full(c_full), .v_half(v_half), .v_full(v_full)
   );

   ata_mul #(.W(DATA_W), .SHARED(SHARED_MUL)) u_mul (
      .a_lo(src_a[HALF_W-1:0]), .b_lo(src_b[HALF_W-1:0]),
      .is_signed(op == OP_SMUL), .prod(prod)
   );

   assign tag_bad  = (|src_a[TAG_W-1:0]) | (|src_b[TAG_W-1:0]);
   assign trap_now = in_valid && (op == OP_TADD) && (tag_bad || v_half);

   assign result    = is_mul ? prod : sum;
   assign result_we = in_valid && (is_arith || is_mul) && !trap_now;

   always_comb begin
      flag_d.c32 = is_sub ? ~c_half : c_half;
      flag_d.c64 = is_sub ? ~c_full : c_full;
      flag_d.v32 = v_half;
      flag_d.v64 = v_full;
   end

   ata_state #(.H(HALF_W)) u_state (
      .clk(clk), .rst_n(rst_n),
      .flag_we(in_valid && is_arith && !trap_now), .flag_d(flag_d),
      .y_we(in_valid && is_mul), .y_d(prod[DATA_W-1:HALF_W]),
      .trap_d(trap_now),
      .flag_q(flag_q), .y_q(y_reg), .trap_q(tag_trap)
   );

   assign flag_c32 = flag_q.c32;
   assign flag_v32 = flag_q.v32;
   assign flag_c64 = flag_q.c64;
   assign flag_v64 = flag_q.v64;
endmodule

// File: rtl/arith_tag_chk.sv
module arith_tag_chk
   import arith_tag_pkg::*;
#(
   parameter int H     = 32,
   parameter int TAG_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       op_sel,
   input logic [TAG_W-1:0] tag_a,
   input logic [TAG_W-1:0] tag_b,
   input logic [H-1:0]     res_hi,
   input logic             result_we,
   input logic [H-1:0]     y_reg,
   input logic             flag_c32,
   input logic             flag_v32,
   input logic             flag_c64,
   input logic             flag_v64,
   input logic             tag_trap
);
   // R7: a tag on either operand blocks the write in the same cycle
   a_r7_tag_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_TADD && ((|tag_a) || (|tag_b))) |-> !result_we);

   // R7: a tag on either operand raises the trap pulse on the next cycle
   a_r7_tag_raises_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_TADD && ((|tag_a) || (|tag_b))) |=> tag_trap);

   // R7: a trapping tagged add leaves the flags alone
   a_r7_trap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_TADD && ((|tag_a) || (|tag_b))) |=>
         $stable({flag_c32, flag_v32, flag_c64, flag_v64}));

   // R9: an idle cycle changes neither Y nor the flags, and no trap follows
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid || op_sel == OP_RSVD) |=>
         ($stable(y_reg) && $stable({flag_c32, flag_v32, flag_c64, flag_v64}) && !tag_trap));

   // R9: no write enable for an idle or reserved cycle
   a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid || op_sel == OP_RSVD) |-> !result_we);

   // R11: multiplies leave the flags alone
   a_r11_mul_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_UMUL || op_sel == OP_SMUL)) |=>
         $stable({flag_c32, flag_v32, flag_c64, flag_v64}));

   // R11: add-type operations leave Y alone
   a_r11_add_keeps_y: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel <= OP_SUBC || op_sel == OP_TADD)) |=> $stable(y_reg));

   // R5: Y takes the upper product word after a multiply
   a_r5_y_follows_product: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_UMUL || op_sel == OP_SMUL)) |=> (y_reg == $past(res_hi)));

   // R1: a plain add or subtract is always written
   a_r1_add_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel <= OP_SUBC) |-> result_we);
endmodule

bind arith_tag_unit arith_tag_chk #(.H(DATA_W/2), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
   .tag_a(src_a[TAG_W-1:0]), .tag_b(src_b[TAG_W-1:0]),
   .res_hi(result[DATA_W-1:DATA_W/2]), .result_we(result_we), .y_reg(y_reg),
   .flag_c32(flag_c32), .flag_v32(flag_v32), .flag_c64(flag_c64),
   .flag_v64(flag_v64), .tag_trap(tag_trap)
);

// File: tb/sim_arith_tag_unit.sv
module sim_arith_tag_unit;
   import arith_tag_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [63:0] src_a = '0, src_b = '0;
   logic        carry_in = 1'b0;
   logic [63:0] result;
   logic        result_we;
   logic [31:0] y_reg;
   logic        flag_c32, flag_v32, flag_c64, flag_v64, tag_trap;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state kept by the bench
   logic [3:0]  m_flags = 4'h0;   // {c32, v32, c64, v64}
   logic [31:0] m_y = '0;

   always #2 clk = ~clk;   // 250 MHz

   arith_tag_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b), .carry_in(carry_in),
      .result(result), .result_we(result_we), .y_reg(y_reg),
      .flag_c32(flag_c32), .flag_v32(flag_v32), .flag_c64(flag_c64),
      .flag_v64(flag_v64), .tag_trap(tag_trap)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input bit v, input logic [2:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic cin, input string tag);
      logic [63:0] e_res;
      logic        e_we, e_trap, upd_f, upd_y, sub_mode, c_eff;
      logic [3:0]  nf;
      logic [63:0] pm;
      e_res = '0; e_we = 1'b0; e_trap = 1'b0; upd_f = 1'b0; upd_y = 1'b0;
      nf = m_flags; pm = '0;
      sub_mode = (op == OP_SUB) || (op == OP_SUBC);
      c_eff = (op == OP_ADDC || op == OP_SUBC) ? cin : 1'b0;
      if (v) begin
         case (op)
            OP_ADD, OP_ADDC, OP_TADD: begin
               logic [64:0] f64; logic [32:0] f32;
               f64 = {1'b0, a} + {1'b0, b} + {64'd0, c_eff};
               f32 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, c_eff};
               e_res = f64[63:0];
               nf[3] = f32[32];
               nf[1] = f64[64];
               nf[2] = (a[31] == b[31]) && (e_res[31] != a[31]);
               nf[0] = (a[63] == b[63]) && (e_res[63] != a[63]);
               if (op == OP_TADD && (a[1:0] != 2'b00 || b[1:0] != 2'b00 || nf[2]))
                  e_trap = 1'b1;
               e_we = !e_trap; upd_f = !e_trap;
            end
            OP_SUB, OP_SUBC: begin
               e_res = a - b - {63'd0, c_eff};
               nf[3] = {2'b0, a[31:0]} < ({2'b0, b[31:0]} + {33'd0, c_eff});
               nf[1] = {2'b0, a} < ({2'b0, b} + {65'd0, c_eff});
               nf[2] = (a[31] != b[31]) && (e_res[31] != a[31]);
               nf[0] = (a[63] != b[63]) && (e_res[63] != a[63]);
               e_we = 1'b1; upd_f = 1'b1;
            end
            OP_UMUL: begin
               pm = {32'd0, a[31:0]} * {32'd0, b[31:0]};
               e_res = pm; e_we = 1'b1; upd_y = 1'b1;
            end
            OP_SMUL: begin
               pm = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
               e_res = pm; e_we = 1'b1; upd_y = 1'b1;
            end
            default: ;
         endcase
      end
      @(negedge clk);
      in_valid = v; op_sel = op; src_a = a; src_b = b; carry_in = cin;
      #1;
      chk(tag, "result_we", {63'd0, result_we}, {63'd0, e_we});
      if (e_we) chk(tag, "result", result, e_res);
      if (upd_f) m_flags = nf;
      if (upd_y) m_y = pm[63:32];
      @(posedge clk); #1;
      chk(tag, "flags c32/v32/c64/v64", {60'd0, flag_c32, flag_v32, flag_c64, flag_v64},
          {60'd0, m_flags});
      chk(tag, "y_reg", {32'd0, y_reg}, {32'd0, m_y});
      chk(tag, "tag_trap", {63'd0, tag_trap}, {63'd0, e_trap});
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10", "y_reg", {32'd0, y_reg}, 64'd0);
      chk("R10", "flags", {60'd0, flag_c32, flag_v32, flag_c64, flag_v64}, 64'd0);
      chk("R10", "tag_trap", {63'd0, tag_trap}, 64'd0);
   endtask

   task automatic t_add_sub;
      apply(1, OP_ADD, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, "R1 R3");
      apply(1, OP_ADD, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, "R1 R4");
      apply(1, OP_ADD, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, "R3 R4 min64");
      apply(1, OP_ADD, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, "R3 R4 min32");
      apply(1, OP_SUB, 64'h5, 64'h7, 0, "R1 R3 borrow");
      apply(1, OP_SUB, 64'h8000_0000_0000_0000, 64'h1, 0, "R4 sub overflow");
      apply(1, OP_SUB, 64'h1234, 64'h1234, 0, "R1 R3 equal");
   endtask

   task automatic t_carry;
      apply(1, OP_ADDC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, "R2 addc cin1");
      apply(1, OP_ADDC, 64'h10, 64'h20, 0, "R2 addc cin0");
      apply(1, OP_SUBC, 64'h10, 64'h10, 1, "R2 subc cin1");
      apply(1, OP_SUBC, 64'h0, 64'h0, 1, "R2 R3 subc borrow");
      apply(1, OP_SUBC, 64'h30, 64'h10, 0, "R2 subc cin0");
   endtask

   task automatic t_mul;
      apply(1, OP_UMUL, 64'hAAAA_0000_FFFF_FFFF, 64'h5555_0000_FFFF_FFFF, 0, "R5 R11 umul max");
      apply(1, OP_SMUL, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 0, "R6 R11 smul -1x-1");
      apply(1, OP_SMUL, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 0, "R6 smul min32");
      apply(1, OP_SMUL, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_0000_0003, 0, "R6 smul neg");
      apply(1, OP_ADD, 64'h3, 64'h4, 0, "R11 add keeps y");
   endtask

   task automatic t_tagged;
      apply(1, OP_TADD, 64'h100, 64'h200, 0, "R8 clean");
      apply(1, OP_ADD, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, "R7 set flags");
      apply(1, OP_TADD, 64'h101, 64'h200, 0, "R7 tag on a only");
      apply(1, OP_TADD, 64'h100, 64'h202, 0, "R7 tag on b only");
      apply(1, OP_TADD, 64'h7FFF_FFFC, 64'h4, 0, "R7 overflow31");
      apply(1, OP_TADD, 64'hFFFF_FFFF_0000_0004, 64'h1_0000_0004, 0, "R8 carry64");
   endtask

   task automatic t_idle;
      apply(1, OP_UMUL, 64'h1234_5678, 64'h9ABC_DEF0, 0, "R9 setup");
      apply(0, OP_ADD, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1, "R9 idle");
      apply(1, OP_RSVD, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 1, "R9 reserved");
   endtask

   task automatic t_random;
      for (int i = 0; i < 300; i++) begin
         logic [2:0] op;
         logic [63:0] a, b;
         string tg;
         op = 3'($urandom_range(0, 6));
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if (i % 4 == 0) begin a[1:0] = 2'b00; b[1:0] = 2'b00; end
         case (op)
            3'd0, 3'd1: tg = "R1 rand";
            3'd2, 3'd3: tg = "R2 rand";
            3'd4:       tg = "R5 rand";
            3'd5:       tg = "R6 rand";
            default:    tg = "R7 rand";
         endcase
         apply(1, op, a, b, 1'($urandom), tg);
      end
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_add_sub();
      t_carry();
      t_mul();
      t_tagged();
      t_idle();
      t_random();
      summary();
   end
endmodule